// File: doc/BRIEF.md
# Gated Programmable Bus Clock Divider

This block produces one divided and gated peripheral bus clock from an input clock. Software sees a single 32-bit control word. It holds a 7-bit ratio field, a read-only ready flag and an enable bit. Besides a plain full-word write, the block has two alias write ports. One sets the enable bit and the other clears it. Each alias acts only when bit 15 of its data is one.

A ratio change goes through a handshake. Accepting a new field value drops ready. The divider then waits for the output period in progress to finish and loads the new ratio at that boundary. Ready returns one cycle later, so software polls ready before it writes and again after. Gating acts at period boundaries only, so the output never shows a shortened high phase.

The control state machine has three states. `ST_IDLE` has ready high and accepts a ratio write. `ST_WAIT_EDGE` holds the accepted value until a period boundary. `ST_SETTLE` lasts one cycle after the load and then returns to `ST_IDLE`. Its transitions are `ST_IDLE` to `ST_WAIT_EDGE` on an accepted write, `ST_WAIT_EDGE` to `ST_SETTLE` when the boundary loads the ratio, and `ST_SETTLE` to `ST_IDLE` unconditionally.

Top module: `pbclk_divider`

## Requirements
- R1: The ratio field sits in bits 6:0 of the control word. With field value F, the output period is F+1 input cycles, for ratios 1 to 128.
- R2: For a ratio N of 2 or more, the output is high for floor(N/2) input cycles, starting each period. For N = 1, the output follows the input clock.
- R3: Ready is bit 11 of the control word. A full-word write accepted while ready is one drops ready from the next cycle. From that same cycle the ratio field reads back the written value.
- R4: A full-word write made while ready is zero leaves the ratio field unchanged, and the output ratio does not change.
- R5: A new ratio takes effect only at an output period boundary, or at once when the output is stopped. Ready is one again one cycle after the new ratio is loaded.
- R6: The enable bit is bit 15. A set-alias write with data bit 15 high sets it, and a clear-alias write with data bit 15 high clears it. Other alias data bits have no effect. A full-word write loads bit 15 directly. A full-word write takes priority over clear, and clear takes priority over set.
- R7: When enable is zero, the output finishes its current period and then stays low. The last high phase keeps its full length.
- R8: After reset the control word reads 0x0000_8801: enabled, ready, and field 1 (divide by 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock, divided by the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 32 | Full-word write data |
| set_en | input | 1 | Set-alias write strobe |
| set_data | input | 32 | Set-alias data; a one in bit 15 sets enable |
| clr_en | input | 1 | Clear-alias write strobe |
| clr_data | input | 32 | Clear-alias data; a one in bit 15 clears enable |
| ctrl_rdata | output | 32 | Control word read-back |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
The bench uses the default 7-bit ratio field, so it reaches the full ratio range from pass-through up to divide-by-128. It measures output periods at ratios 2, 5, 6, 8 and 128 and compares them against expected high and low times. It also covers a write made while a change is still pending, and a stop and restart through the alias ports.

// File: rtl/pbclk_pkg.sv
package pbclk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_EDGE = 2'd1,
        ST_SETTLE    = 2'd2
    } ctl_state_e;

    localparam int READY_BIT  = 11;
    localparam int ENABLE_BIT = 15;
endpackage

// File: rtl/pbclk_ctrl_fsm.sv
module pbclk_ctrl_fsm
    import pbclk_pkg::*;
#(
    parameter int DIV_W     = 7,
    parameter int RESET_DIV = 1
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             boundary,
    output logic             ready,
    output logic             load,
    output logic [DIV_W-1:0] tgt_div
);
    ctl_state_e state_q, state_d;
    logic [DIV_W-1:0] tgt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (div_wr) state_d = ST_WAIT_EDGE;
            ST_WAIT_EDGE: if (boundary) state_d = ST_SETTLE;
            ST_SETTLE:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= DIV_W'(RESET_DIV);
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && div_wr)
                tgt_q <= div_wdata;
        end
    end

    always_comb begin
        ready   = 1'b0;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE:      ready = 1'b1;
            ST_WAIT_EDGE: load  = boundary;
            ST_SETTLE:    ;
            default:      ;
        endcase
        tgt_div = tgt_q;
    end

    AST_WRITE_DROPS_READY: assert property (@(posedge clk_in) disable iff (!rst_n)
        (ready && div_wr) |=> !ready); // R3
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!ready && div_wr) |=> $stable(tgt_q)); // R4
    AST_READY_AFTER_LOAD: assert property (@(posedge clk_in) disable iff (!rst_n)
        load |=> ##1 ready); // R5
endmodule

// File: rtl/pbclk_div_core.sv
module pbclk_div_core #(
    parameter int DIV_W     = 7,
    parameter int RESET_DIV = 1
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             load,
    input  logic [DIV_W-1:0] div_new,
    output logic             boundary,
    output logic             clk_out
);
    localparam int CW = DIV_W + 1;

    logic [DIV_W-1:0] cur_div_q, cur_div_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic             run_q, run_d;
    logic             out_q, out_d;
    logic             wrap;
    logic             pass_gate_q;
    logic [CW-1:0]    half_d;

    assign wrap     = run_q && (cnt_q == cur_div_q);
    assign boundary = wrap || !run_q;

    always_comb begin
        cur_div_d = load ? div_new : cur_div_q;
        if (!run_q || wrap) run_d = enable;
        else                run_d = 1'b1;
        if (run_q && !wrap) cnt_d = cnt_q + 1'b1;
        else                cnt_d = '0;
        half_d = ({1'b0, cur_div_d} + CW'(1)) >> 1;
        out_d  = run_d && (cur_div_d != '0) && ({1'b0, cnt_d} < half_d);
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            cur_div_q <= DIV_W'(RESET_DIV);
            cnt_q     <= '0;
            run_q     <= 1'b0;
            out_q     <= 1'b0;
        end else begin
            cur_div_q <= cur_div_d;
            cnt_q     <= cnt_d;
            run_q     <= run_d;
            out_q     <= out_d;
        end
    end

    // pass-through gate changes only while the input clock is low
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) pass_gate_q <= 1'b0;
        else        pass_gate_q <= run_q && (cur_div_q == '0);
    end

    assign clk_out = (cur_div_q == '0) ? (clk_in & pass_gate_q) : out_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk_in) disable iff (!rst_n)
        run_q |-> (cnt_q <= cur_div_q)); // R1
    AST_RATIO_AT_EDGE: assert property (@(posedge clk_in) disable iff (!rst_n)
        !$stable(cur_div_q) |-> $past(boundary)); // R5
    AST_NO_RUNT_STOP: assert property (@(posedge clk_in) disable iff (!rst_n)
        $fell(run_q) |-> $past(wrap)); // R7
    AST_STOPPED_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
        !run_q |-> !out_q); // R7
endmodule

// File: rtl/pbclk_divider.sv
module pbclk_divider
    import pbclk_pkg::*;
#(
    parameter int DIV_W     = 7,
    parameter int RESET_DIV = 1
) (
    input  logic        clk_in,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        set_en,
    input  logic [31:0] set_data,
    input  logic        clr_en,
    input  logic [31:0] clr_data,
    output logic [31:0] ctrl_rdata,
    output logic        clk_out
);
    logic             en_q;
    logic             ready, load, boundary;
    logic [DIV_W-1:0] tgt_div;

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n)                          en_q <= 1'b1;
        else if (wr_en)                      en_q <= wr_data[ENABLE_BIT];
        else if (clr_en && clr_data[ENABLE_BIT]) en_q <= 1'b0;
        else if (set_en && set_data[ENABLE_BIT]) en_q <= 1'b1;
    end

    pbclk_ctrl_fsm #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_fsm (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .div_wr    (wr_en),
        .div_wdata (wr_data[DIV_W-1:0]),
        .boundary  (boundary),
        .ready     (ready),
        .load      (load),
        .tgt_div   (tgt_div)
    );

    pbclk_div_core #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_core (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .enable   (en_q),
        .load     (load),
        .div_new  (tgt_div),
        .boundary (boundary),
        .clk_out  (clk_out)
    );

    always_comb begin
        ctrl_rdata               = '0;
        ctrl_rdata[DIV_W-1:0]    = tgt_div;
        ctrl_rdata[READY_BIT]    = ready;
        ctrl_rdata[ENABLE_BIT]   = en_q;
    end

    AST_SET_ALIAS: assert property (@(posedge clk_in) disable iff (!rst_n)
        (set_en && set_data[ENABLE_BIT] && !wr_en && !clr_en) |=> en_q); // R6
    AST_CLR_ALIAS: assert property (@(posedge clk_in) disable iff (!rst_n)
        (clr_en && clr_data[ENABLE_BIT] && !wr_en) |=> !en_q); // R6
endmodule

// File: tb/pbclk_divider_tb_top.sv
module pbclk_divider_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, set_en = 1'b0, clr_en = 1'b0;
    logic [31:0] wr_data = '0, set_data = '0, clr_data = '0;
    logic [31:0] ctrl_rdata;
    logic        clk_out;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int skip = 0;
    int last_hi = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    pbclk_divider dut_i (
        .clk_in(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data),
        .set_en(set_en), .set_data(set_data),
        .clr_en(clr_en), .clr_data(clr_data),
        .ctrl_rdata(ctrl_rdata), .clk_out(clk_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: measures each output period a quarter cycle after the edge
    always @(posedge clk) begin
        static bit prev = 0;
        static int hi = 0, lo = 0;
        #(CLK_P/4);
        if (rst_n) begin
            if (clk_out && !prev) begin
                if (hi > 0) begin
                    if (skip > 0) skip--;
                    else if (exp_q.size() > 0) begin
                        int e;
                        e = exp_q.pop_front();
                        check(hi == e / 1024 && lo == e % 1024, "R1/R2 period",
                              hi * 1024 + lo, e);
                    end
                end
                hi = 1; lo = 0;
            end else if (clk_out) hi++;
            else begin
                if (prev) last_hi = hi;
                lo++;
            end
            prev = clk_out;
        end
    end

    task automatic reg_write(input int kind, input logic [31:0] d);
        @(negedge clk);
        case (kind)
            0: begin wr_en = 1; wr_data = d; end
            1: begin set_en = 1; set_data = d; end
            default: begin clr_en = 1; clr_data = d; end
        endcase
        @(negedge clk);
        wr_en = 0; set_en = 0; clr_en = 0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (ctrl_rdata[11]) break;
        end
        check(ctrl_rdata[11] == 1'b1, "R5 ready returns", ctrl_rdata[11], 1);
    endtask

    task automatic expect_periods(input int n, input int cnt);
        int h;
        h = n / 2;
        for (int i = 0; i < cnt; i++) exp_q.push_back(h * 1024 + (n - h));
        skip = 1;
        for (int i = 0; i < 2000 && exp_q.size() > 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R1 periods observed", exp_q.size(), 0);
        exp_q.delete();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(ctrl_rdata == 32'h0000_8801, "R8 reset word", ctrl_rdata, 32'h8801);
        expect_periods(2, 3);

        // R3: accepted write drops ready and shows the field; R4: busy write ignored
        reg_write(0, 32'h0000_8004);
        check(ctrl_rdata[11] == 1'b0, "R3 ready low", ctrl_rdata[11], 0);
        check(ctrl_rdata[6:0] == 7'd4, "R3 field readback", ctrl_rdata[6:0], 4);
        reg_write(0, 32'h0000_8007);
        wait_ready();
        check(ctrl_rdata[6:0] == 7'd4, "R4 busy write ignored", ctrl_rdata[6:0], 4);
        expect_periods(5, 3);

        reg_write(0, 32'h0000_8007);
        wait_ready();
        check(ctrl_rdata[6:0] == 7'd7, "R5 new ratio", ctrl_rdata[6:0], 7);
        expect_periods(8, 3);

        // R2 pass-through
        reg_write(0, 32'h0000_8000);
        wait_ready();
        repeat (2) @(posedge clk);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            #(CLK_P/4);
            check(clk_out == 1'b1, "R2 pass high", clk_out, 1);
            #(CLK_P/2);
            check(clk_out == 1'b0, "R2 pass low", clk_out, 0);
        end

        reg_write(0, 32'h0000_807F);
        wait_ready();
        expect_periods(128, 2);

        reg_write(0, 32'h0000_8005);
        wait_ready();
        expect_periods(6, 2);

        // R6: alias bits other than bit 15 have no effect
        reg_write(1, 32'h0000_007F);
        @(negedge clk);
        check(ctrl_rdata == 32'h0000_8805, "R6 alias other bits", ctrl_rdata, 32'h8805);

        // R6/R7: clear alias stops the clock after a full period
        reg_write(2, 32'h0000_8000);
        check(ctrl_rdata[15] == 1'b0, "R6 clear alias", ctrl_rdata[15], 0);
        repeat (20) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            @(posedge clk);
            #(CLK_P/4);
            check(clk_out == 1'b0, "R7 held low", clk_out, 0);
        end
        check(last_hi == 3, "R7 last high full", last_hi, 3);

        reg_write(1, 32'h0000_8000);
        check(ctrl_rdata[15] == 1'b1, "R6 set alias", ctrl_rdata[15], 1);
        expect_periods(6, 2);

        // R6: full write loads bit 15 directly
        reg_write(0, 32'h0000_0005);
        wait_ready();
        check(ctrl_rdata[15] == 1'b0, "R6 full write enable", ctrl_rdata[15], 0);
        repeat (20) @(negedge clk);
        @(posedge clk);
        #(CLK_P/4);
        check(clk_out == 1'b0, "R7 low after full write", clk_out, 0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule